// File: doc/BRIEF.md
# Dual-channel serial ADC frame reader

This block is the host-side master for a two-channel serial converter whose outputs come out on two data lines. A start request arrives on a valid/ready pair. When it is accepted, the block drives chip-select low and then toggles a serial clock whose half period is a whole number of system clocks. It samples the data lines on each falling serial-clock edge that it makes. When the frame is done it raises chip-select and shows two 12-bit results for one cycle with a valid pulse.

Each channel frame on a data line carries two zero bits, then the 12 result bits MSB first, and may end with two padding zeros. The mode input sets how many serial clocks a frame has. In the short and padded modes each line carries its own channel. In the dual mode line A carries both channels one after the other and line B is not read. The bits in the two leading-zero positions are checked and any one reported as a framing error. After every frame, chip-select stays high for a programmable quiet interval before the next start is accepted.

The start interface is valid/ready. A start is accepted only on a cycle where both `start_valid` and `start_ready` are high. The requester may hold `start_valid` for as long as it likes, and the block applies back-pressure by keeping `start_ready` low for the whole frame and its quiet interval. The result side has no back-pressure: it is a single-cycle strobe, and the result registers keep their values until the next frame completes.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, `cs_n` = 1, `sclk` = 1, `start_ready` = 1, `res_valid` = 0, `frame_err` = 0 and both results are 0.
- R2: A start is taken only when `start_valid` and `start_ready` are both high, and `cs_n` falls on that clock edge. `start_ready` stays low while `cs_n` is low and during the quiet interval. A `start_valid` pulse made while `start_ready` is low is dropped and starts no frame.
- R3: `sclk` is high whenever `cs_n` is high. The first falling `sclk` edge comes one half period after `cs_n` falls, so no falling edge shares a clock cycle with the falling edge of `cs_n`.
- R4: Each `sclk` high and low phase lasts H = max(`half_div`, 2) system clocks, with `half_div` latched at the start. `cs_n` is therefore low for 2·N·H cycles, where N is the edge count of the frame.
- R5: The mode value gives N. `mode` = 2'b00 gives 14 falling edges, 2'b01 gives 16, and 2'b10 or 2'b11 gives 32. `mode` is latched at the start.
- R6: In the 14 and 16 modes, `res_a` is made of `sd_a` sampled on falling edges 3 to 14, MSB first, and `res_b` is made of `sd_b` sampled on the same edges. The values on edges 15 and 16 are not used.
- R7: In the 32 mode, `res_a` comes from `sd_a` on edges 3 to 14 and `res_b` comes from `sd_a` on edges 19 to 30. `sd_b` has no effect on the results or on `frame_err`.
- R8: `frame_err` is 1 if a leading-zero position is sampled as 1. Those positions are edges 1 and 2 on both lines in the 14 and 16 modes, and edges 1, 2, 17 and 18 on `sd_a` in the 32 mode. A 1 on any other edge does not set it.
- R9: `res_valid` is high for exactly one cycle, in the cycle where `cs_n` has just returned high. `res_a`, `res_b` and `frame_err` are updated at that moment and then hold until the next frame ends.
- R10: `start_ready` goes high `quiet_cycles`+1 cycles after `cs_n` rises, so `cs_n` stays high for at least `quiet_cycles`+1 cycles between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Start request, valid side |
| start_ready | output | 1 | Start request can be accepted |
| mode | input | 2 | Frame length select (14 / 16 / 32 edges) |
| half_div | input | DIV_W | System clocks per serial-clock half period (values below 2 are treated as 2) |
| quiet_cycles | input | QUIET_W | Quiet interval after each frame |
| cs_n | output | 1 | Converter chip-select, active low |
| sclk | output | 1 | Serial clock to the converter, idles high |
| sd_a | input | 1 | Data line A |
| sd_b | input | 1 | Data line B |
| res_valid | output | 1 | One-cycle result strobe |
| res_a | output | DATA_W | Channel A result |
| res_b | output | DATA_W | Channel B result |
| frame_err | output | 1 | Leading-zero framing error of the last frame |

## Verification
The bound checker looks at the pin-level protocol on every cycle. It checks that the serial clock stays high while deselected, that no falling edge happens while chip-select is just falling, that no clock phase is shorter than two system clocks, that the result strobe is a single cycle seen only with chip-select high, and that ready is never shown during a frame. Only the bench scenarios can show the things that depend on data and counts. These are the exact edge count for each mode, the total time chip-select is low, the placement of the 12-bit fields on the right edges, that line B is ignored in the 32 mode, which injected ones do or do not raise the framing flag, the length of the quiet interval, and that a start request made while busy is dropped.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_QUIET = 2'd2
  } rd_state_t;

  localparam int LEAD_BITS  = 2;
  localparam int TRAIL_BITS = 2;
  localparam int MIN_HALF   = 2;
endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  import adc_rd_pkg::*;

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  // Any ratio below the minimum is raised to it.
  always_comb begin
    if (half_div < DIV_W'(MIN_HALF)) lim = DIV_W'(MIN_HALF - 1);
    else                             lim = half_div - 1'b1;
  end

  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int DATA_W = 12,
  parameter int EDGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              fall,
  input  logic [EDGE_W-1:0] edge_idx,
  input  logic              dual,
  input  logic              sd_a,
  input  logic              sd_b,
  output logic [DATA_W-1:0] word_a,
  output logic [DATA_W-1:0] word_b,
  output logic              lead_err
);
  import adc_rd_pkg::*;

  localparam int CH_EDGES = LEAD_BITS + DATA_W + TRAIL_BITS;
  localparam logic [EDGE_W-1:0] D_FIRST  = EDGE_W'(LEAD_BITS + 1);
  localparam logic [EDGE_W-1:0] D_LAST   = EDGE_W'(LEAD_BITS + DATA_W);
  localparam logic [EDGE_W-1:0] D2_FIRST = EDGE_W'(CH_EDGES + LEAD_BITS + 1);
  localparam logic [EDGE_W-1:0] D2_LAST  = EDGE_W'(CH_EDGES + LEAD_BITS + DATA_W);
  localparam logic [EDGE_W-1:0] L1_LAST  = EDGE_W'(LEAD_BITS);
  localparam logic [EDGE_W-1:0] L2_FIRST = EDGE_W'(CH_EDGES + 1);
  localparam logic [EDGE_W-1:0] L2_LAST  = EDGE_W'(CH_EDGES + LEAD_BITS);

  logic in_first, in_second, lead_first, lead_second;

  always_comb begin
    in_first    = (edge_idx >= D_FIRST) && (edge_idx <= D_LAST);
    in_second   = dual && (edge_idx >= D2_FIRST) && (edge_idx <= D2_LAST);
    lead_first  = (edge_idx <= L1_LAST);
    lead_second = dual && (edge_idx >= L2_FIRST) && (edge_idx <= L2_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_a   <= '0;
      word_b   <= '0;
      lead_err <= 1'b0;
    end else if (clear) begin
      word_a   <= '0;
      word_b   <= '0;
      lead_err <= 1'b0;
    end else if (fall) begin
      if (in_first)          word_a <= {word_a[DATA_W-2:0], sd_a};
      if (in_first && !dual) word_b <= {word_b[DATA_W-2:0], sd_b};
      if (in_second)         word_b <= {word_b[DATA_W-2:0], sd_a};
      if (lead_first && (sd_a || (sd_b && !dual))) lead_err <= 1'b1;
      if (lead_second && sd_a)                     lead_err <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DATA_W  = 12,
  parameter int DIV_W   = 8,
  parameter int QUIET_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_valid,
  output logic               start_ready,
  input  logic [1:0]         mode,
  input  logic [DIV_W-1:0]   half_div,
  input  logic [QUIET_W-1:0] quiet_cycles,
  output logic               cs_n,
  output logic               sclk,
  input  logic               sd_a,
  input  logic               sd_b,
  output logic               res_valid,
  output logic [DATA_W-1:0]  res_a,
  output logic [DATA_W-1:0]  res_b,
  output logic               frame_err
);
  import adc_rd_pkg::*;

  localparam int CH_EDGES = LEAD_BITS + DATA_W + TRAIL_BITS;
  localparam int EDGE_W   = $clog2(2 * CH_EDGES + 1);

  function automatic logic [EDGE_W-1:0] frame_edges(input logic [1:0] m);
    if (m[1])      return EDGE_W'(2 * CH_EDGES);
    else if (m[0]) return EDGE_W'(CH_EDGES);
    else           return EDGE_W'(LEAD_BITS + DATA_W);
  endfunction

  rd_state_t          state;
  logic [1:0]         mode_q;
  logic [DIV_W-1:0]   div_q;
  logic [QUIET_W-1:0] quiet_q, quiet_cnt;
  logic [EDGE_W-1:0]  edge_cnt;
  logic               tick, accept, fall_evt, finish;
  logic [DATA_W-1:0]  word_a, word_b;
  logic               lead_err;

  assign start_ready = (state == ST_IDLE);
  assign accept      = start_valid && start_ready;
  assign fall_evt    = (state == ST_SHIFT) && tick && sclk;
  assign finish      = (state == ST_SHIFT) && tick && !sclk && (edge_cnt == frame_edges(mode_q));

  adc_rd_sclk_gen #(.DIV_W(DIV_W)) u_sclk_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state == ST_SHIFT),
    .half_div (div_q),
    .tick     (tick)
  );

  adc_rd_capture #(.DATA_W(DATA_W), .EDGE_W(EDGE_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .fall     (fall_evt),
    .edge_idx (edge_cnt + 1'b1),
    .dual     (mode_q[1]),
    .sd_a     (sd_a),
    .sd_b     (sd_b),
    .word_a   (word_a),
    .word_b   (word_b),
    .lead_err (lead_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cs_n      <= 1'b1;
      sclk      <= 1'b1;
      mode_q    <= '0;
      div_q     <= '0;
      quiet_q   <= '0;
      quiet_cnt <= '0;
      edge_cnt  <= '0;
      res_valid <= 1'b0;
      res_a     <= '0;
      res_b     <= '0;
      frame_err <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            mode_q   <= mode;
            div_q    <= half_div;
            quiet_q  <= quiet_cycles;
            edge_cnt <= '0;
            cs_n     <= 1'b0;
            state    <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (fall_evt) begin
            sclk     <= 1'b0;
            edge_cnt <= edge_cnt + 1'b1;
          end else if (finish) begin
            sclk      <= 1'b1;
            cs_n      <= 1'b1;
            res_valid <= 1'b1;
            res_a     <= word_a;
            res_b     <= word_b;
            frame_err <= lead_err;
            quiet_cnt <= '0;
            state     <= ST_QUIET;
          end else if (tick) begin
            sclk <= 1'b1;
          end
        end
        ST_QUIET: begin
          if (quiet_cnt == quiet_q) state <= ST_IDLE;
          else                      quiet_cnt <= quiet_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic start_ready,
  input logic res_valid
);
  assert_sclk_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  assert_no_fall_at_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $past(!cs_n));

  assert_half_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) |=> (sclk == $past(sclk)));

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_valid_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (cs_n && $past(!cs_n)));

  assert_ready_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> cs_n);
endmodule

bind adc_frame_reader adc_frame_reader_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .sclk        (sclk),
  .start_ready (start_ready),
  .res_valid   (res_valid)
);

// File: tb/adc_frame_reader_tb.sv
`timescale 1ns/1ps
module adc_frame_reader_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_valid = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] half_div = 8'd2;
  logic [7:0] quiet_cycles = 8'd0;
  logic       sd_a = 1'b0, sd_b = 1'b0;
  logic       start_ready, cs_n, sclk, res_valid, frame_err;
  logic [11:0] res_a, res_b;

  int n_tests = 0;
  int n_fail  = 0;

  // converter model state
  logic [11:0] mdl_a = '0, mdl_b = '0;
  int  idx = 0;
  int  err_pos = -1;
  bit  b_noise = 1'b0;

  always #10 clk = ~clk;

  adc_frame_reader u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .mode(mode), .half_div(half_div), .quiet_cycles(quiet_cycles),
    .cs_n(cs_n), .sclk(sclk), .sd_a(sd_a), .sd_b(sd_b),
    .res_valid(res_valid), .res_a(res_a), .res_b(res_b), .frame_err(frame_err)
  );

  function automatic logic bitval(input int i, input logic [11:0] own, input logic [11:0] other);
    int j = i % 16;
    logic [11:0] w = (i < 16) ? own : other;
    if (j >= 2 && j <= 13) return w[13 - j];
    return 1'b0;
  endfunction

  // idx 0 is presented at the select edge; each falling sclk moves on one bit
  always @(negedge cs_n or negedge sclk) begin
    if (!cs_n) begin
      if (sclk) idx = 0;
      else      idx = idx + 1;
      sd_a = (idx == err_pos) ? 1'b1 : bitval(idx, mdl_a, mdl_b);
      sd_b = b_noise ? 1'b1 : bitval(idx, mdl_b, mdl_a);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic give_start();
    while (!start_ready) @(negedge clk);
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  task automatic run_frame(input logic [1:0] m, input int div, input int q,
                           input logic [11:0] a, input logic [11:0] b,
                           input int epos, input bit noise, input int exp_err,
                           input int exp_b);
    int n_edges, h, n_low, n_fall, first_fall, guard, k;
    logic prev;
    n_edges = m[1] ? 32 : (m[0] ? 16 : 14);
    h = (div < 2) ? 2 : div;
    mode = m; half_div = 8'(div); quiet_cycles = 8'(q);
    mdl_a = a; mdl_b = b; err_pos = epos; b_noise = noise;
    give_start();
    n_low = 0; n_fall = 0; first_fall = -1; guard = 0; prev = 1'b1;
    while (!res_valid && guard < 20000) begin
      if (!cs_n) begin
        n_low++;
        if (prev && !sclk) begin
          n_fall++;
          if (first_fall < 0) first_fall = n_low;
        end
      end
      prev = sclk;
      guard++;
      @(negedge clk);
    end
    chk("R5", "falling edges", n_fall, n_edges);
    chk("R4", "cs_n low cycles", n_low, 2 * n_edges * h);
    chk("R3", "first fall sample", first_fall, h + 1);
    chk("R9", "cs_n at valid", int'(cs_n), 1);
    chk(m[1] ? "R7" : "R6", "res_a", int'(res_a), int'(a));
    chk(m[1] ? "R7" : "R6", "res_b", int'(res_b), exp_b);
    chk("R8", "frame_err", int'(frame_err), exp_err);
    k = 0;
    while (!start_ready && k < 1000) begin
      k++;
      @(negedge clk);
      if (k == 1) chk("R9", "valid one cycle", int'(res_valid), 0);
    end
    chk("R10", "quiet cycles", k, q + 1);
    chk("R9", "res_a held", int'(res_a), int'(a));
    err_pos = -1; b_noise = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "cs_n", int'(cs_n), 1);
    chk("R1", "sclk", int'(sclk), 1);
    chk("R1", "start_ready", int'(start_ready), 1);
    chk("R1", "res_valid", int'(res_valid), 0);
    chk("R1", "frame_err", int'(frame_err), 0);
    chk("R1", "res_a", int'(res_a), 0);
  endtask

  task automatic t_busy_drop();
    int low_seen;
    mode = 2'b00; half_div = 8'd2; quiet_cycles = 8'd2;
    mdl_a = 12'h321; mdl_b = 12'h654;
    give_start();
    repeat (10) @(negedge clk);
    chk("R2", "ready while busy", int'(start_ready), 0);
    start_valid = 1'b1;
    repeat (5) @(negedge clk);
    start_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    low_seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (!cs_n) low_seen++;
    end
    chk("R2", "dropped start frames", low_seen, 0);
    chk("R2", "ready after quiet", int'(start_ready), 1);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_frame(2'b00, 2, 3, 12'hABC, 12'h123, -1, 1'b0, 0, 12'h123);
    run_frame(2'b01, 3, 0, 12'hFFF, 12'h001, -1, 1'b0, 0, 12'h001);
    run_frame(2'b10, 2, 1, 12'h5A5, 12'hA5A, -1, 1'b1, 0, 12'hA5A);
    run_frame(2'b11, 4, 5, 12'h801, 12'h7FE, -1, 1'b1, 0, 12'h7FE);
    run_frame(2'b00, 0, 0, 12'h0F0, 12'hF0F, -1, 1'b0, 0, 12'hF0F);
    run_frame(2'b00, 2, 0, 12'h111, 12'h222, 0, 1'b0, 1, 12'h222);
    run_frame(2'b10, 2, 0, 12'h333, 12'h444, 16, 1'b0, 1, 12'h444);
    run_frame(2'b00, 2, 0, 12'h555, 12'h666, 16, 1'b0, 0, 12'h666);
    run_frame(2'b01, 2, 0, 12'h777, 12'h888, 14, 1'b0, 0, 12'h888);
    t_busy_drop();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule